// File: doc/BRIEF.md
# Attention Row Engine with Piecewise-Linear Softmax

This block produces one output row of single-head scaled dot-product attention for a single query vector. The query is loaded element by element while the engine is idle. After a start pulse the engine takes in N key vectors on a valid/ready stream. For each key it forms the dot product with the query and scales it by an arithmetic right shift. It keeps the scaled scores in a small register buffer and tracks their maximum.

In the second pass the value vectors arrive on a separate valid/ready stream, in the same token order as the keys. Each buffered score is centred on the maximum, and the clamped difference goes through a 16-segment piecewise-linear approximation of the natural exponential. The resulting weight scales the value vector into wide accumulators and is also added to a weight sum. When the last value has been taken, a sequential restoring divider normalizes each accumulated element by the sum, one element after the other. A single-cycle done pulse then marks the output vector as valid.

Only registers and logic hold the state: there is no block memory.

Top module: `attn_row_engine`

## Requirements
- R1: While idle, `q_we` writes `q_data` into query element `q_idx`. Query writes while busy are ignored.
- R2: A start pulse in idle raises `k_ready`. The engine then accepts exactly N keys. Score i is (sum over j of q_j·k_ij) arithmetically shifted right by floor(ceil(log2 D)/2).
- R3: For each token, t = max_score − score_i, which is never negative. Any t of 8·2^SFRAC or more (an input of −8 or below) saturates to the final knot.
- R4: The weights are 16-bit values. Knot y_k is round(32768·e^(−k/2)) for k = 0..16. With s = floor(t / 2^(SFRAC−1)) and f = t mod 2^(SFRAC−1), the weight is y_s − floor((y_s − y_(s+1))·f / 2^(SFRAC−1)).
- R5: `v_ready` rises only after the N-th key has been accepted, and `k_ready` is then low. Value i is scaled by the weight of key i, so both streams must follow the same token order.
- R6: The accumulators hold sum_i w_i·v_ij exactly, and the weight sum holds sum_i w_i exactly. The sum is at least 32768, because the maximum token has weight 32768.
- R7: Output element j is the signed W-bit quotient acc_j / sum, truncated toward zero. It sits at bits [j·W +: W] of `out_data`.
- R8: `done` is high for exactly one cycle, D·(W + ceil(log2 N) + 20) cycles after the clock edge that accepts the last value.
- R9: A start pulse while the engine is busy is ignored. It does not change the result or the timing.
- R10: After reset, `k_ready`, `v_ready` and `done` are low and `out_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a row when idle |
| q_we | input | 1 | Query element write enable |
| q_idx | input | max(1,ceil(log2 D)) | Query element index |
| q_data | input | W | Query element, signed |
| k_valid | input | 1 | Key vector valid |
| k_ready | output | 1 | Key vector accepted when high with valid |
| k_data | input | D·W | Key vector, element j at [j·W +: W] |
| v_valid | input | 1 | Value vector valid |
| v_ready | output | 1 | Value vector accepted when high with valid |
| v_data | input | D·W | Value vector, element j at [j·W +: W] |
| out_data | output | D·W | Normalized output row |
| done | output | 1 | One-cycle pulse when `out_data` is valid |

## Verification
The bench builds the engine with N = 8 tokens, D = 4 elements, 16-bit operands and SFRAC = 6, which gives a score shift of one bit. Query and key magnitudes around ±24 spread the centred exponent inputs over the whole [−8, 0] range. This small geometry brings within reach every segment of the exponential, the exact saturation threshold and the one-below-threshold interpolation, as well as rows where all weights are equal. The divider latency is short enough that the latency, the ignored start and the ignored query write can each be checked on several complete rows.

// File: rtl/attn_pkg.sv
package attn_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KEYS,
    ST_VALS,
    ST_DIVGO,
    ST_DIVWAIT
  } row_state_e;

  localparam int WEIGHT_W   = 16;
  localparam int WEIGHT_ONE = 32768;

  // Knots of e^(-k/2) in 1.15 unsigned fixed point, k = 0..16.
  function automatic logic [WEIGHT_W-1:0] exp_knot(input logic [4:0] k);
    case (k)
      5'd0:    return 16'd32768;
      5'd1:    return 16'd19875;
      5'd2:    return 16'd12055;
      5'd3:    return 16'd7312;
      5'd4:    return 16'd4435;
      5'd5:    return 16'd2690;
      5'd6:    return 16'd1631;
      5'd7:    return 16'd990;
      5'd8:    return 16'd600;
      5'd9:    return 16'd364;
      5'd10:   return 16'd221;
      5'd11:   return 16'd134;
      5'd12:   return 16'd81;
      5'd13:   return 16'd49;
      5'd14:   return 16'd30;
      5'd15:   return 16'd18;
      default: return 16'd11;
    endcase
  endfunction

endpackage

// File: rtl/attn_pwl_exp.sv
module attn_pwl_exp
  import attn_pkg::*;
#(
  parameter int TW    = 40,
  parameter int SFRAC = 8
) (
  input  logic [TW-1:0]       mag,
  output logic [WEIGHT_W-1:0] weight
);
  localparam int FB = SFRAC - 1;

  logic                     sat;
  logic [4:0]               seg;
  logic [FB-1:0]            frac;
  logic [WEIGHT_W-1:0]      y_lo, y_hi, knot_gap, drop;
  logic [WEIGHT_W+FB-1:0]   prod;

  always_comb begin
    sat      = |mag[TW-1:SFRAC+3];
    seg      = {1'b0, mag[FB+3:FB]};
    frac     = mag[FB-1:0];
    y_lo     = exp_knot(seg);
    y_hi     = exp_knot(seg + 5'd1);
    knot_gap = y_lo - y_hi;
    prod     = {{FB{1'b0}}, knot_gap} * {{WEIGHT_W{1'b0}}, frac};
    drop     = WEIGHT_W'(prod >> FB);
    weight   = sat ? exp_knot(5'd16) : (y_lo - drop);
  end

endmodule

// File: rtl/attn_dot.sv
module attn_dot #(
  parameter int D  = 64,
  parameter int W  = 16,
  parameter int OW = 2*W + $clog2(D) + 1
) (
  input  logic [D*W-1:0]       a,
  input  logic [D*W-1:0]       b,
  output logic signed [OW-1:0] dot
);
  logic signed [2*W-1:0] prod [D];

  for (genvar i = 0; i < D; i++) begin : g_mul
    assign prod[i] = $signed(a[i*W +: W]) * $signed(b[i*W +: W]);
  end

  always_comb begin
    dot = '0;
    for (int i = 0; i < D; i++) dot = dot + OW'(prod[i]);
  end

endmodule

// File: rtl/attn_divider.sv
module attn_divider #(
  parameter int NW   = 40,
  parameter int DVW  = 24,
  parameter int OUTW = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   go,
  input  logic signed [NW-1:0]   num,
  input  logic [DVW-1:0]         den,
  output logic                   fin,
  output logic signed [OUTW-1:0] quot
);
  localparam int CW = $clog2(NW + 1);

  logic            busy;
  logic [NW-1:0]   q_sh;
  logic [DVW-1:0]  rem;
  logic            neg;
  logic [CW-1:0]   step;
  logic [DVW:0]    trial;
  logic            fits;

  always_comb begin
    trial = {rem, q_sh[NW-1]};
    fits  = trial >= {1'b0, den};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      fin  <= 1'b0;
      q_sh <= '0;
      rem  <= '0;
      neg  <= 1'b0;
      step <= '0;
    end else begin
      fin <= 1'b0;
      if (go && !busy) begin
        busy <= 1'b1;
        neg  <= num[NW-1];
        q_sh <= num[NW-1] ? NW'(-num) : num;
        rem  <= '0;
        step <= '0;
      end else if (busy) begin
        rem  <= fits ? DVW'(trial - {1'b0, den}) : DVW'(trial);
        q_sh <= {q_sh[NW-2:0], fits};
        step <= step + CW'(1);
        if (step == CW'(NW - 1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end

  assign quot = neg ? -$signed(q_sh[OUTW-1:0]) : $signed(q_sh[OUTW-1:0]);

  // R7: a quotient is only reported after a division was running
  a_r7_fin_after_busy: assert property (@(posedge clk) disable iff (rst)
    fin |-> $past(busy));

  // R7: restoring remainder stays below the divisor
  a_r7_rem_below_den: assert property (@(posedge clk) disable iff (rst)
    busy |-> (rem < den));

endmodule

// File: rtl/attn_row_engine.sv
module attn_row_engine
  import attn_pkg::*;
#(
  parameter int N     = 197,
  parameter int D     = 64,
  parameter int W     = 16,
  parameter int SFRAC = 8,
  localparam int IW   = (D > 1) ? $clog2(D) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           q_we,
  input  logic [IW-1:0]  q_idx,
  input  logic [W-1:0]   q_data,
  input  logic           k_valid,
  output logic           k_ready,
  input  logic [D*W-1:0] k_data,
  input  logic           v_valid,
  output logic           v_ready,
  input  logic [D*W-1:0] v_data,
  output logic [D*W-1:0] out_data,
  output logic           done
);
  localparam int SH   = $clog2(D) / 2;
  localparam int SW   = 2*W + $clog2(D) + 1;
  localparam int TW   = SW + 1;
  localparam int TKW  = $clog2(N);
  localparam int SUMW = WEIGHT_W + $clog2(N) + 1;
  localparam int PRW  = W + WEIGHT_W + 1;
  localparam int AW   = PRW + $clog2(N) + 1;

  row_state_e state;

  logic [W-1:0]         q_vec   [D];
  logic [D*W-1:0]       q_flat;
  logic signed [SW-1:0] score_buf [N];
  logic signed [SW-1:0] row_max;
  logic [TKW-1:0]       tok;
  logic                 last_tok;
  logic signed [AW-1:0] acc     [D];
  logic [SUMW-1:0]      wsum;
  logic [IW-1:0]        el;
  logic [W-1:0]         out_vec [D];
  logic                 done_q;

  logic signed [SW-1:0] dot_raw, score, cur_score;
  logic signed [TW-1:0] t_full;
  logic [TW-1:0]        t_mag;
  logic [WEIGHT_W-1:0]  w;
  logic signed [PRW-1:0] wprod [D];
  logic                 k_fire, v_fire;
  logic                 div_fin;
  logic signed [W-1:0]  div_q;

  assign k_ready  = (state == ST_KEYS);
  assign v_ready  = (state == ST_VALS);
  assign k_fire   = k_valid && k_ready;
  assign v_fire   = v_valid && v_ready;
  assign last_tok = (tok == TKW'(N - 1));
  assign done     = done_q;

  // Query register file and output packing
  for (genvar j = 0; j < D; j++) begin : g_elem
    assign q_flat[j*W +: W]   = q_vec[j];
    assign out_data[j*W +: W] = out_vec[j];

    always_ff @(posedge clk) begin
      if (rst) q_vec[j] <= '0;
      else if (state == ST_IDLE && q_we && q_idx == IW'(j)) q_vec[j] <= q_data;
    end

    assign wprod[j] = $signed({1'b0, w}) * $signed(v_data[j*W +: W]);

    always_ff @(posedge clk) begin
      if (rst) acc[j] <= '0;
      else if (state == ST_IDLE && start) acc[j] <= '0;
      else if (v_fire) acc[j] <= acc[j] + AW'(wprod[j]);
    end

    always_ff @(posedge clk) begin
      if (rst) out_vec[j] <= '0;
      else if (state == ST_DIVWAIT && div_fin && el == IW'(j)) out_vec[j] <= div_q;
    end
  end

  // Pass one: score
  attn_dot #(.D(D), .W(W), .OW(SW)) u_dot (
    .a   (q_flat),
    .b   (k_data),
    .dot (dot_raw)
  );
  assign score = dot_raw >>> SH;

  always_ff @(posedge clk) begin
    if (k_fire) score_buf[tok] <= score;
  end

  // Pass two: centred exponent and weight
  assign cur_score = score_buf[tok];
  assign t_full    = TW'(row_max) - TW'(cur_score);
  assign t_mag     = t_full;

  attn_pwl_exp #(.TW(TW), .SFRAC(SFRAC)) u_exp (
    .mag    (t_mag),
    .weight (w)
  );

  // Normalization
  attn_divider #(.NW(AW), .DVW(SUMW), .OUTW(W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .go   (state == ST_DIVGO),
    .num  (acc[el]),
    .den  (wsum),
    .fin  (div_fin),
    .quot (div_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      tok     <= '0;
      el      <= '0;
      row_max <= '0;
      wsum    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_KEYS;
            tok   <= '0;
            wsum  <= '0;
          end
        end
        ST_KEYS: begin
          if (k_fire) begin
            if (tok == '0 || score > row_max) row_max <= score;
            if (last_tok) begin
              state <= ST_VALS;
              tok   <= '0;
            end else begin
              tok <= tok + TKW'(1);
            end
          end
        end
        ST_VALS: begin
          if (v_fire) begin
            wsum <= wsum + SUMW'(w);
            if (last_tok) begin
              state <= ST_DIVGO;
              el    <= '0;
            end else begin
              tok <= tok + TKW'(1);
            end
          end
        end
        ST_DIVGO: state <= ST_DIVWAIT;
        ST_DIVWAIT: begin
          if (div_fin) begin
            if (el == IW'(D - 1)) begin
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              el    <= el + IW'(1);
              state <= ST_DIVGO;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: the value pass opens only right after a key was taken
  a_r5_vals_after_keys: assert property (@(posedge clk) disable iff (rst)
    $rose(v_ready) |-> $past(k_fire));

  // R3: centred exponent input is never positive
  a_r3_centred: assert property (@(posedge clk) disable iff (rst)
    v_fire |-> !t_full[TW-1]);

  // R4: weight stays between the last and first knot
  a_r4_weight_range: assert property (@(posedge clk) disable iff (rst)
    v_fire |-> (w <= 16'd32768 && w >= 16'd11));

  // R6: the maximum token contributes a full unit weight
  a_r6_sum_floor: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DIVGO) |-> (wsum >= SUMW'(WEIGHT_ONE)));

  // R8: done is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: start during the key pass does not move the token count
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (state == ST_KEYS && start && !k_fire) |=> $stable(tok));

endmodule

// File: tb/tb_attn_row_engine.sv
`timescale 1ns/1ps
module tb_attn_row_engine;
  localparam int N     = 8;
  localparam int D     = 4;
  localparam int W     = 16;
  localparam int SFRAC = 6;
  localparam int IW    = 2;
  localparam int AW    = W + 18 + $clog2(N);
  localparam int LAT   = D * (AW + 2);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic           q_we = 1'b0;
  logic [IW-1:0]  q_idx = '0;
  logic [W-1:0]   q_data = '0;
  logic           k_valid = 1'b0;
  logic           k_ready;
  logic [D*W-1:0] k_data = '0;
  logic           v_valid = 1'b0;
  logic           v_ready;
  logic [D*W-1:0] v_data = '0;
  logic [D*W-1:0] out_data;
  logic           done;

  int  n_checks = 0;
  int  n_fails  = 0;
  longint cyc = 0;

  int     qv [D];
  int     kv [N][D];
  int     vv [N][D];
  longint exp_out [D];
  longint kn [17];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  attn_row_engine #(.N(N), .D(D), .W(W), .SFRAC(SFRAC)) dut (
    .clk(clk), .rst(rst), .start(start),
    .q_we(q_we), .q_idx(q_idx), .q_data(q_data),
    .k_valid(k_valid), .k_ready(k_ready), .k_data(k_data),
    .v_valid(v_valid), .v_ready(v_ready), .v_data(v_data),
    .out_data(out_data), .done(done)
  );

  task automatic check(input string req, input longint got, input longint expv);
    n_checks++;
    if (got !== expv) begin
      n_fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, expv);
    end
  endtask

  function automatic longint weight_of(input longint t);
    longint s, f;
    if (t >= (64'sd8 <<< SFRAC)) return kn[16];
    s = t >>> (SFRAC - 1);
    f = t % (64'sd1 <<< (SFRAC - 1));
    return kn[s] - (((kn[s] - kn[s+1]) * f) >>> (SFRAC - 1));
  endfunction

  task automatic compute_ref();
    longint sc [N];
    longint mx, sum, a;
    for (int i = 0; i < N; i++) begin
      sc[i] = 0;
      for (int j = 0; j < D; j++) sc[i] += longint'(qv[j]) * longint'(kv[i][j]);
      sc[i] = sc[i] >>> 1;
    end
    mx = sc[0];
    for (int i = 1; i < N; i++) if (sc[i] > mx) mx = sc[i];
    sum = 0;
    for (int i = 0; i < N; i++) sum += weight_of(mx - sc[i]);
    for (int j = 0; j < D; j++) begin
      a = 0;
      for (int i = 0; i < N; i++) a += weight_of(mx - sc[i]) * longint'(vv[i][j]);
      exp_out[j] = a / sum;
    end
  endtask

  task automatic load_q();
    for (int j = 0; j < D; j++) begin
      @(negedge clk);
      q_we = 1'b1; q_idx = IW'(j); q_data = W'(qv[j]);
    end
    @(negedge clk);
    q_we = 1'b0;
  endtask

  task automatic run_row(input bit disturb, input bit gaps);
    longint c0;
    load_q();
    compute_ref();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R2 k_ready after start", k_ready, 1);
    check("R5 v_ready low in key pass", v_ready, 0);
    for (int i = 0; i < N; i++) begin
      if (gaps) repeat ($urandom_range(2)) @(negedge clk);
      k_valid = 1'b1;
      for (int j = 0; j < D; j++) k_data[j*W +: W] = W'(kv[i][j]);
      if (disturb && i == 3) begin
        start = 1'b1; q_we = 1'b1; q_idx = '0; q_data = 16'd12345;
      end
      while (!k_ready) @(negedge clk);
      @(negedge clk);
      k_valid = 1'b0; start = 1'b0; q_we = 1'b0;
    end
    check("R5 k_ready low after N keys", k_ready, 0);
    check("R5 v_ready high after N keys", v_ready, 1);
    for (int i = 0; i < N; i++) begin
      if (gaps) repeat ($urandom_range(2)) @(negedge clk);
      v_valid = 1'b1;
      for (int j = 0; j < D; j++) v_data[j*W +: W] = W'(vv[i][j]);
      while (!v_ready) @(negedge clk);
      @(negedge clk);
      v_valid = 1'b0;
    end
    c0 = cyc;
    if (disturb) begin
      repeat (5) @(negedge clk);
      start = 1'b1; q_we = 1'b1; q_idx = 2'd1; q_data = 16'd777;
      @(negedge clk);
      start = 1'b0; q_we = 1'b0;
    end
    while (!done) @(negedge clk);
    check(disturb ? "R9 latency with ignored start" : "R8 latency", cyc - c0, LAT);
    for (int j = 0; j < D; j++)
      check(disturb ? "R1 R9 output after busy writes" : "R7 output element",
            longint'($signed(out_data[j*W +: W])), exp_out[j]);
    @(negedge clk);
    check("R8 done one cycle", done, 0);
    check("R9 idle after row", k_ready, 0);
  endtask

  task automatic rand_row(input int qk_range);
    for (int j = 0; j < D; j++) qv[j] = int'($urandom_range(2*qk_range)) - qk_range;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < D; j++) begin
        kv[i][j] = int'($urandom_range(2*qk_range)) - qk_range;
        vv[i][j] = int'($urandom_range(65535)) - 32768;
      end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 17; k++) kn[k] = longint'($rtoi($exp(-0.5 * k) * 32768.0 + 0.5));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 k_ready reset", k_ready, 0);
    check("R10 v_ready reset", v_ready, 0);
    check("R10 done reset", done, 0);
    check("R10 out_data reset", (out_data == '0), 1);

    // R6 R7: equal keys give a plain truncated mean
    rand_row(24);
    for (int i = 0; i < N; i++) for (int j = 0; j < D; j++) kv[i][j] = 5;
    run_row(1'b0, 1'b0);

    // R3 R4: saturation boundary t = 512 and interpolation at t = 511
    qv = '{1, 0, 0, 0};
    rand_row(0);
    qv = '{1, 0, 0, 0};
    begin
      int k0 [N] = '{1024, 0, 2, -1, 1023, 64, 600, -500};
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < D; j++) kv[i][j] = 0;
        kv[i][0] = k0[i];
        for (int j = 0; j < D; j++) vv[i][j] = (i % 2 == 0) ? 30000 - 1000*j : -29000 + 777*j;
      end
    end
    run_row(1'b0, 1'b1);

    // R3: one dominant key, all others far below
    rand_row(24);
    for (int j = 0; j < D; j++) begin qv[j] = 24; kv[5][j] = 24; end
    run_row(1'b0, 1'b1);

    // R2 R4 R7: random rows across the exponent range
    for (int r = 0; r < 6; r++) begin
      rand_row(24);
      run_row(1'b0, r[0]);
    end

    // R1 R9: start and query writes while busy are ignored
    rand_row(20);
    run_row(1'b1, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule